// File: doc/BRIEF.md
# Channel Status Capture and Compare

This block sits behind the frame decoder of a serial digital audio receiver. Each audio frame carries one channel status bit, and 192 frames make up a status block. The block keeps the leading 48 of those bits for every block. It compares each newly completed 48-bit word with the word kept from the block before it. When the two words are identical, it raises a sticky update flag that a controller can use as an interrupt. This lets software read the status bytes only when they have settled, instead of polling once per block.

Readout is a byte-addressed combinational multiplexer. Address 0 returns a status byte. It packs a 3-bit rate code from the rate estimator with the live error and non-PCM indications, all sampled at the moment of the read. Addresses 1 to 6 return the last completed 48-bit word, eight bits per address. Loss of receiver lock invalidates the stored word, so the first block after relock can never raise the flag.

Top module: `cs_capture_top`

## Requirements
- R1: After synchronous reset, `upd_flag` is 0 and addresses 1 to 6 read 0x00.
- R2: Once the 48th strobed frame after a block marker is registered, address `1+n/8` bit position `n%8` holds status bit n of that block for n = 0..47, where bit 0 is the frame that carries the marker. Frames 48 onward of a block leave the readout unchanged.
- R3: Address 0 reads `{2'b00, rate_code[2:0], 1'b0, nonpcm_bit, err_bit}`, so bits 7, 6 and 2 are always 0 and the rate code sits in bits 5 to 3.
- R4: The error bit (address 0, bit 0) equals `link_err | ~pll_locked` combinationally, in the same cycle as the inputs.
- R5: The non-PCM bit (address 0, bit 1) equals `nonpcm_det` combinationally, in the same cycle.
- R6: When a block completes 48 frames while locked, a valid previous word is held, and the two words are equal, `upd_flag` is 1 from the next clock edge on.
- R7: A completed block whose 48 bits differ from the held word in any position does not set `upd_flag`. It still replaces the held word.
- R8: A block cut short by a new marker before its 48th frame is discarded. It is neither compared nor stored, and the counter restarts from the new marker.
- R9: `upd_flag` stays 1 until a cycle with `flag_clr` = 1 clears it at the next edge. A match in the same cycle as `flag_clr` wins, and the flag stays 1.
- R10: Any cycle with `pll_locked` = 0 invalidates the held word. The next block completed after relock cannot set the flag, and the block after that can.
- R11: Addresses above 6 read 0x00.
- R12: `cs_bit` and `blk_start` have no effect in cycles where `frame_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| cs_bit | input | 1 | Channel status bit of the strobed frame |
| blk_start | input | 1 | Strobed frame is bit 0 of a new status block |
| pll_locked | input | 1 | Receiver clock recovery is locked |
| link_err | input | 1 | Transmission error seen on the link |
| nonpcm_det | input | 1 | Non-PCM payload detected |
| rate_code | input | 3 | Sample rate estimate code |
| flag_clr | input | 1 | Clears the update flag |
| rd_addr | input | 3 | Readout byte address |
| rd_data | output | 8 | Readout byte |
| upd_flag | output | 1 | Sticky flag: block matched the previous one |

## Verification
The hardest state to reach from the ports is a match that lands on the very cycle a clear is requested. The stimulus sends the same 48-bit pattern twice and raises `flag_clr` exactly on the 48th strobed frame of the second block. Two other orderings also need sequences several blocks long: a short block followed by a full one, and an unlock pulse between two identical blocks. These are driven as full block sequences, with idle cycles between frames. In those idle cycles, `cs_bit` and `blk_start` carry random values without a strobe.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int CS_KEEP_BITS = 48;
    localparam int CS_RATE_W    = 3;

    typedef enum logic {
        COL_WAIT = 1'b0,
        COL_FILL = 1'b1
    } col_state_t;

    typedef struct packed {
        logic [CS_RATE_W-1:0] rate;
        logic                 nonpcm;
        logic                 err;
    } live_stat_t;

    function automatic logic [7:0] pack_status(input live_stat_t s);
        return {2'b00, s.rate, 1'b0, s.nonpcm, s.err};
    endfunction

endpackage

// File: rtl/cs_bit_collector.sv
module cs_bit_collector
    import cs_pkg::*;
#(
    parameter int KEEP = CS_KEEP_BITS,
    localparam int CW = $clog2(KEEP + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_stb,
    input  logic            cs_bit,
    input  logic            blk_start,
    output logic            done,
    output logic [KEEP-1:0] word
);

    col_state_t      state;
    logic [CW-1:0]   cnt;
    logic [KEEP-1:0] cap;
    logic            at_last;

    assign at_last = (cnt == CW'(KEEP - 1));
    assign done    = frame_stb && !blk_start && (state == COL_FILL) && at_last;

    always_comb begin
        word = cap;
        if (done) word[KEEP-1] = cs_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= COL_WAIT;
            cnt   <= '0;
        end else if (frame_stb) begin
            if (blk_start) begin
                state <= COL_FILL;
                cnt   <= CW'(1);
            end else if (state == COL_FILL) begin
                if (at_last) state <= COL_WAIT;
                else         cnt   <= cnt + CW'(1);
            end
        end
    end

    for (genvar i = 0; i < KEEP; i++) begin : g_cap
        logic wr;
        if (i == 0) begin : g_first
            assign wr = frame_stb && blk_start;
        end else begin : g_rest
            assign wr = frame_stb && !blk_start && (state == COL_FILL) && (cnt == CW'(i));
        end
        always_ff @(posedge clk) begin
            if (rst)     cap[i] <= 1'b0;
            else if (wr) cap[i] <= cs_bit;
        end
    end

endmodule

// File: rtl/cs_block_compare.sv
module cs_block_compare #(
    parameter int KEEP = 48
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            done,
    input  logic [KEEP-1:0] word,
    input  logic            pll_locked,
    input  logic            flag_clr,
    output logic [KEEP-1:0] held,
    output logic            match,
    output logic            upd_flag
);

    logic held_valid;

    assign match = done && pll_locked && held_valid && (word == held);

    always_ff @(posedge clk) begin
        if (rst) begin
            held       <= '0;
            held_valid <= 1'b0;
            upd_flag   <= 1'b0;
        end else begin
            if (done) held <= word;

            if (!pll_locked) held_valid <= 1'b0;
            else if (done)   held_valid <= 1'b1;

            if (match)         upd_flag <= 1'b1;
            else if (flag_clr) upd_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/cs_readout_mux.sv
module cs_readout_mux
    import cs_pkg::*;
#(
    parameter int KEEP = CS_KEEP_BITS,
    parameter int AW   = 3,
    localparam int NB    = KEEP / 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic [AW-1:0]   rd_addr,
    input  logic [KEEP-1:0] held,
    input  live_stat_t      stat,
    output logic [7:0]      rd_data
);

    logic [7:0] bank [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_bank
        if (g == 0) begin : g_stat
            assign bank[g] = pack_status(stat);
        end else if (g <= NB) begin : g_word
            assign bank[g] = held[8*(g-1) +: 8];
        end else begin : g_pad
            assign bank[g] = 8'h00;
        end
    end

    assign rd_data = bank[rd_addr];

endmodule

// File: rtl/cs_capture_top.sv
module cs_capture_top
    import cs_pkg::*;
#(
    parameter int KEEP_BITS = CS_KEEP_BITS,
    parameter int ADDR_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_stb,
    input  logic                 cs_bit,
    input  logic                 blk_start,
    input  logic                 pll_locked,
    input  logic                 link_err,
    input  logic                 nonpcm_det,
    input  logic [CS_RATE_W-1:0] rate_code,
    input  logic                 flag_clr,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [7:0]           rd_data,
    output logic                 upd_flag
);

    logic                 cap_done;
    logic [KEEP_BITS-1:0] cap_word;
    logic [KEEP_BITS-1:0] held_word;
    logic                 cmp_match;
    live_stat_t           live;

    assign live.rate   = rate_code;
    assign live.nonpcm = nonpcm_det;
    assign live.err    = link_err | ~pll_locked;

    cs_bit_collector #(.KEEP(KEEP_BITS)) u_col (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .cs_bit    (cs_bit),
        .blk_start (blk_start),
        .done      (cap_done),
        .word      (cap_word)
    );

    cs_block_compare #(.KEEP(KEEP_BITS)) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .done       (cap_done),
        .word       (cap_word),
        .pll_locked (pll_locked),
        .flag_clr   (flag_clr),
        .held       (held_word),
        .match      (cmp_match),
        .upd_flag   (upd_flag)
    );

    cs_readout_mux #(.KEEP(KEEP_BITS), .AW(ADDR_W)) u_mux (
        .rd_addr (rd_addr),
        .held    (held_word),
        .stat    (live),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/cs_capture_chk.sv
module cs_capture_chk #(
    parameter int AW = 3,
    parameter int NB = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          pll_locked,
    input logic          link_err,
    input logic          nonpcm_det,
    input logic          flag_clr,
    input logic          upd_flag,
    input logic [AW-1:0] rd_addr,
    input logic [7:0]    rd_data,
    input logic          done_evt,
    input logic          match_evt
);

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        upd_flag && !flag_clr |=> upd_flag); // R9

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flag_clr && !match_evt |=> !upd_flag); // R9

    AST_RISE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(upd_flag) |-> $past(match_evt)); // R6

    AST_MATCH_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        match_evt |-> done_evt && pll_locked); // R8

    AST_NO_RISE_AFTER_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        !pll_locked |=> !$rose(upd_flag)); // R10

    AST_STATUS_ZEROS: assert property (@(posedge clk) disable iff (rst)
        rd_addr == '0 |-> (rd_data[7:6] == 2'b00) && !rd_data[2]); // R3

    AST_ERR_LIVE: assert property (@(posedge clk) disable iff (rst)
        rd_addr == '0 |-> rd_data[0] == (link_err || !pll_locked)); // R4

    AST_NONPCM_LIVE: assert property (@(posedge clk) disable iff (rst)
        rd_addr == '0 |-> rd_data[1] == nonpcm_det); // R5

    AST_HIGH_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        int'(rd_addr) > NB |-> rd_data == 8'h00); // R11

endmodule

bind cs_capture_top cs_capture_chk #(.AW(ADDR_W), .NB(KEEP_BITS / 8)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pll_locked (pll_locked),
    .link_err   (link_err),
    .nonpcm_det (nonpcm_det),
    .flag_clr   (flag_clr),
    .upd_flag   (upd_flag),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .done_evt   (cap_done),
    .match_evt  (cmp_match)
);

// File: tb/tb_cs_capture_top.sv
`timescale 1ns/1ps
module tb_cs_capture_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_stb = 1'b0, cs_bit = 1'b0, blk_start = 1'b0;
    logic       pll_locked = 1'b1, link_err = 1'b0, nonpcm_det = 1'b0;
    logic [2:0] rate_code = 3'd0;
    logic       flag_clr = 1'b0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       upd_flag;

    int    n_vec = 0, n_bad = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // behavioural reference
    int          m_pos;
    logic [47:0] m_cur, m_held;
    bit          m_valid, m_flag;

    always #2 clk = ~clk;

    cs_capture_top dut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .cs_bit(cs_bit),
        .blk_start(blk_start), .pll_locked(pll_locked), .link_err(link_err),
        .nonpcm_det(nonpcm_det), .rate_code(rate_code), .flag_clr(flag_clr),
        .rd_addr(rd_addr), .rd_data(rd_data), .upd_flag(upd_flag)
    );

    task automatic model_edge();
        bit fin, hit;
        fin = 0;
        if (rst) begin
            m_pos = -1; m_cur = '0; m_held = '0; m_valid = 0; m_flag = 0;
            return;
        end
        if (frame_stb) begin
            if (blk_start) begin
                m_cur[0] = cs_bit; m_pos = 1;
            end else if (m_pos >= 1 && m_pos < 48) begin
                m_cur[m_pos] = cs_bit; m_pos++;
                if (m_pos == 48) begin fin = 1; m_pos = -1; end
            end
        end
        hit = fin && pll_locked && m_valid && (m_cur == m_held);
        if (fin) m_held = m_cur;
        if (!pll_locked) m_valid = 0; else if (fin) m_valid = 1;
        if (hit) m_flag = 1; else if (flag_clr) m_flag = 0;
    endtask

    task automatic compare();
        logic [7:0] exp;
        string tag;
        int a = int'(rd_addr);
        if (a == 0) begin
            exp = {2'b00, rate_code, 1'b0, nonpcm_det, link_err | ~pll_locked};
            tag = (cur_req == "R4" || cur_req == "R5") ? cur_req : "R3";
        end else if (a <= 6) begin
            exp = m_held[8*(a-1) +: 8];
            tag = (cur_req == "R1") ? "R1" : "R2";
        end else begin
            exp = 8'h00; tag = "R11";
        end
        n_vec++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s rd_data addr %0d actual %h expected %h", tag, a, rd_data, exp);
        end
        n_vec++;
        if (upd_flag !== m_flag) begin
            n_bad++;
            $display("FAIL %s upd_flag actual %b expected %b", cur_req, upd_flag, m_flag);
        end
    endtask

    task automatic step(input logic s, input logic b, input logic k, input logic c);
        frame_stb = s; cs_bit = b; blk_start = k; flag_clr = c;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        rd_addr = rd_addr + 3'd1;
    endtask

    // idle cycles carry random cs_bit / blk_start without a strobe (R12)
    task automatic send_block(input logic [47:0] pat, input int nfr, input int clr_at);
        for (int f = 0; f < nfr; f++) begin
            step(1'b1, (f < 48) ? pat[f] : 1'($urandom), f == 0, f == clr_at);
            step(1'b0, 1'($urandom), 1'($urandom), 1'b0);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'($urandom), 1'($urandom), 1'b0);
    endtask

    localparam logic [47:0] PAT_A = 48'h0123_4567_89AB;
    localparam logic [47:0] PAT_B = 48'hF00D_5A5A_C3E1;
    localparam logic [47:0] PAT_C = 48'hF00D_5A5A_C3E0;

    initial begin
        // R1: reset state
        cur_req = "R1";
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
        rst = 1'b0;
        idle(8);
        // R12: strobe-less garbage only, readout must stay zero
        cur_req = "R12";
        idle(16);
        // R2: first block captured, no compare possible yet
        cur_req = "R2";
        send_block(PAT_A, 192, -1);
        // R6: identical block sets the flag
        cur_req = "R6";
        send_block(PAT_A, 192, -1);
        idle(4);
        // R9: flag sticky, then cleared by pulse
        cur_req = "R9";
        idle(10);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        idle(4);
        // R7: differing block (single bit) sets nothing
        cur_req = "R7";
        send_block(PAT_B, 192, -1);
        send_block(PAT_C, 192, -1);
        // R9: match and clear in the same cycle, match wins
        cur_req = "R9";
        send_block(PAT_C, 192, 47);
        idle(4);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        // R8: short block discarded, restart counts from new marker
        cur_req = "R8";
        send_block(PAT_A, 30, -1);
        send_block(PAT_C, 192, -1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        // R10: unlock invalidates held word
        cur_req = "R10";
        pll_locked = 1'b0;
        idle(6);
        pll_locked = 1'b1;
        send_block(PAT_C, 192, -1);
        send_block(PAT_C, 192, -1);
        // R3/R4/R5/R11: live status byte
        cur_req = "R4";
        for (int i = 0; i < 40; i++) begin
            link_err = 1'($urandom); pll_locked = 1'($urandom);
            rate_code = 3'($urandom);
            step(1'b0, 1'b0, 1'b0, 1'b0);
        end
        pll_locked = 1'b1; link_err = 1'b0;
        cur_req = "R5";
        for (int i = 0; i < 40; i++) begin
            nonpcm_det = 1'($urandom); rate_code = 3'($urandom);
            step(1'b0, 1'b0, 1'b0, 1'b0);
        end
        cur_req = "R3";
        idle(16);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule